// File: doc/BRIEF.md
# Selectable-Ratio Word Packer and Unpacker

This block connects a 32-bit message-buffer memory to a narrower target bus during block transfers. A transfer starts with a pulse on `start_i`, together with a direction, a packing format and a length. The length counts target words.

In the unpack direction, the block fetches 32-bit memory words and splits each one into one to four target words, which it sends out over a valid/ready handshake. In the pack direction, it collects target words from a valid/ready input and merges them into 32-bit memory words, which it presents for writing. With any packing format active, the first value of a memory word sits in its least significant lane. With no packing, each memory word passes through whole.

The sequencer has six states:
- IDLE: waiting for a start.
- FETCH: taking a memory word.
- EMIT: sending target words from the held memory word.
- COLLECT: taking target words into the accumulator.
- FLUSH: offering the accumulated memory word.
- FINISH: the one-cycle done state.

Its transitions are:
- start → FETCH, COLLECT or FINISH.
- fetch-accept → EMIT.
- emit-accept → next lane, FETCH or FINISH.
- collect-accept → next lane or FLUSH.
- flush-accept → COLLECT or FINISH.
- FINISH → IDLE.

Top module: `pk_word_packer`

## Requirements
- R1: `fmt_i` encodes the format as 2'b00 = one 32-bit value per memory word, 2'b01 = two 16-bit values, 2'b10 = three 10-bit values in bits [29:0], 2'b11 = four 8-bit values. The block samples `fmt_i`, `dir_i` and `count_i` only when a start is accepted; changes during a transfer have no effect.
- R2: In a packed format, value k of a memory word (k = 0 first) occupies bits [k*w+w-1 : k*w], where w is the lane width. The lane index of an active transfer never reaches the lane count.
- R3: In the 2'b00 format, each target word equals one whole memory word, unchanged.
- R4: `count_i` is the number of target words. An unpack transfer emits exactly `count_i` target words. A transfer in either direction moves ceil(`count_i`/lanes) memory words.
- R5: On unpack, lanes past the final value of a partly filled memory word are never emitted. Every emitted target word is zero above its lane width.
- R6: On pack (`dir_i` = 1), unused lanes of the final memory word are written as zero. In the 2'b10 format, bits [31:30] are zero. Bits of `tgt_in_data_i` above the lane width are ignored.
- R7: While `tgt_out_valid_o` or `mem_wr_valid_o` is high and not accepted, it stays high with stable data on the next cycle.
- R8: `done_o` is high for exactly one cycle. On unpack, it is high in the cycle after the last target word is accepted. On pack, it is high in the cycle after the last memory word is accepted. With `count_i` = 0, it is high in the cycle after the start.
- R9: `busy_o` is high from the cycle after an accepted start through the done cycle. A start while busy is ignored. The two directions never handshake at the same time.
- R10: Synchronous active-high `rst` clears the state, lane index, counter and partial pack word. After a reset, all valid, ready, busy and done outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, taken in IDLE only |
| dir_i | input | 1 | 0 = unpack memory to target, 1 = pack target to memory |
| fmt_i | input | 2 | Packing format code |
| count_i | input | CNT_W | Transfer length in target words |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_rd_valid_i | input | 1 | Memory word available for unpacking |
| mem_rd_data_i | input | 32 | Memory word to unpack |
| mem_rd_ready_o | output | 1 | Block takes the memory word |
| tgt_out_valid_o | output | 1 | Target word available |
| tgt_out_data_o | output | 32 | Target word, zero above the lane width |
| tgt_out_ready_i | input | 1 | Target side takes the word |
| tgt_in_valid_i | input | 1 | Target word offered for packing |
| tgt_in_data_i | input | 32 | Target word to pack |
| tgt_in_ready_o | output | 1 | Block takes the target word |
| mem_wr_valid_o | output | 1 | Packed memory word available |
| mem_wr_data_o | output | 32 | Packed memory word |
| mem_wr_ready_i | input | 1 | Memory takes the packed word |

## Verification
The properties assume that reset is held across the first clock edges, so the sequencer starts from a known state. They also assume that ready and valid inputs only qualify a transfer and never need to be withdrawn in step with the block's own valid. The stimulus drives every input half a period away from the rising edge and raises reset before the first edge. It stalls the ready and valid inputs on fixed modulo patterns. It also pulses a second start, with a different format and direction, in the middle of a transfer, so that the sampling rule is exercised without breaking the handshake assumptions.

// File: rtl/pk_types_pkg.sv
package pk_types_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned LANE_IDX_W = 2;
    localparam int unsigned LANE_CNT_W = 3;

    typedef enum logic [1:0] {
        FMT_NONE = 2'b00,
        FMT_2X16 = 2'b01,
        FMT_3X10 = 2'b10,
        FMT_4X8  = 2'b11
    } pk_fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EMIT,
        ST_COLLECT,
        ST_FLUSH,
        ST_FINISH
    } pk_state_e;

    // Number of values per memory word for a format.
    function automatic logic [LANE_CNT_W-1:0] lanes_of(input pk_fmt_e f);
        logic [LANE_CNT_W-1:0] n;
        unique case (f)
            FMT_NONE: n = 3'd1;
            FMT_2X16: n = 3'd2;
            FMT_3X10: n = 3'd3;
            FMT_4X8:  n = 3'd4;
        endcase
        return n;
    endfunction

    // Width in bits of one lane.
    function automatic logic [5:0] width_of(input pk_fmt_e f);
        logic [5:0] w;
        unique case (f)
            FMT_NONE: w = 6'd32;
            FMT_2X16: w = 6'd16;
            FMT_3X10: w = 6'd10;
            FMT_4X8:  w = 6'd8;
        endcase
        return w;
    endfunction

    // Mask of the bits one lane keeps, aligned at bit 0.
    function automatic logic [WORD_W-1:0] lane_mask(input pk_fmt_e f);
        logic [WORD_W-1:0] m;
        unique case (f)
            FMT_NONE: m = '1;
            FMT_2X16: m = 32'h0000_FFFF;
            FMT_3X10: m = 32'h0000_03FF;
            FMT_4X8:  m = 32'h0000_00FF;
        endcase
        return m;
    endfunction

    // Bit offset of a lane: lane 0 is least significant.
    function automatic logic [4:0] shift_of(input pk_fmt_e f,
                                            input logic [LANE_IDX_W-1:0] lane);
        logic [7:0] p;
        p = 8'(width_of(f)) * 8'(lane);
        return p[4:0];
    endfunction

endpackage

// File: rtl/pk_lane_extract.sv
module pk_lane_extract
    import pk_types_pkg::*;
(
    input  logic [WORD_W-1:0]     word_i,
    input  pk_fmt_e               fmt_i,
    input  logic [LANE_IDX_W-1:0] lane_i,
    output logic [WORD_W-1:0]     value_o
);

    logic [WORD_W-1:0] shifted;

    always_comb begin
        shifted = word_i >> shift_of(fmt_i, lane_i);
        value_o = shifted & lane_mask(fmt_i);
    end

endmodule

// File: rtl/pk_lane_ctrl.sv
module pk_lane_ctrl
    import pk_types_pkg::*;
#(
    parameter int unsigned CNT_W = 16
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load_i,
    input  logic [CNT_W-1:0]      count_i,
    input  logic                  step_i,
    input  logic [LANE_CNT_W-1:0] lanes_i,
    output logic [LANE_IDX_W-1:0] lane_o,
    output logic [CNT_W-1:0]      rem_o,
    output logic                  last_val_o,
    output logic                  last_lane_o,
    output logic                  rem_zero_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_o <= '0;
            rem_o  <= '0;
        end else if (load_i) begin
            lane_o <= '0;
            rem_o  <= count_i;
        end else if (step_i) begin
            rem_o  <= rem_o - CNT_W'(1);
            lane_o <= last_lane_o ? '0 : lane_o + LANE_IDX_W'(1);
        end
    end

    assign last_val_o  = (rem_o == CNT_W'(1));
    assign rem_zero_o  = (rem_o == '0);
    assign last_lane_o = ({1'b0, lane_o} == (lanes_i - LANE_CNT_W'(1)));

endmodule

// File: rtl/pk_pack_acc.sv
module pk_pack_acc
    import pk_types_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_i,
    input  logic                  add_i,
    input  pk_fmt_e               fmt_i,
    input  logic [LANE_IDX_W-1:0] lane_i,
    input  logic [WORD_W-1:0]     din_i,
    output logic [WORD_W-1:0]     acc_o
);

    logic [WORD_W-1:0] placed;

    always_comb begin
        placed = (din_i & lane_mask(fmt_i)) << shift_of(fmt_i, lane_i);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            acc_o <= '0;
        end else if (add_i) begin
            acc_o <= acc_o | placed;
        end
    end

endmodule

// File: rtl/pk_word_packer.sv
module pk_word_packer
    import pk_types_pkg::*;
#(
    parameter int unsigned CNT_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dir_i,
    input  logic [1:0]        fmt_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              busy_o,
    output logic              done_o,
    input  logic              mem_rd_valid_i,
    input  logic [WORD_W-1:0] mem_rd_data_i,
    output logic              mem_rd_ready_o,
    output logic              tgt_out_valid_o,
    output logic [WORD_W-1:0] tgt_out_data_o,
    input  logic              tgt_out_ready_i,
    input  logic              tgt_in_valid_i,
    input  logic [WORD_W-1:0] tgt_in_data_i,
    output logic              tgt_in_ready_o,
    output logic              mem_wr_valid_o,
    output logic [WORD_W-1:0] mem_wr_data_o,
    input  logic              mem_wr_ready_i
);

    pk_state_e             state_q, state_d;
    pk_fmt_e               fmt_q;
    logic [WORD_W-1:0]     hold_q;
    logic [WORD_W-1:0]     acc_q;
    logic [WORD_W-1:0]     lane_val;
    logic [LANE_IDX_W-1:0] lane_q;
    logic [CNT_W-1:0]      rem_q;
    logic                  last_val, last_lane, rem_zero;
    logic                  start_ok, fetch_acc, emit_acc, take_acc, flush_acc;

    // Handshake events, qualified by state.
    assign start_ok  = (state_q == ST_IDLE)    && start_i;
    assign fetch_acc = (state_q == ST_FETCH)   && mem_rd_valid_i;
    assign emit_acc  = (state_q == ST_EMIT)    && tgt_out_ready_i;
    assign take_acc  = (state_q == ST_COLLECT) && tgt_in_valid_i;
    assign flush_acc = (state_q == ST_FLUSH)   && mem_wr_ready_i;

    pk_lane_ctrl #(.CNT_W(CNT_W)) lane_ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .load_i      (start_ok),
        .count_i     (count_i),
        .step_i      (emit_acc || take_acc),
        .lanes_i     (lanes_of(fmt_q)),
        .lane_o      (lane_q),
        .rem_o       (rem_q),
        .last_val_o  (last_val),
        .last_lane_o (last_lane),
        .rem_zero_o  (rem_zero)
    );

    pk_lane_extract extract_i (
        .word_i  (hold_q),
        .fmt_i   (fmt_q),
        .lane_i  (lane_q),
        .value_o (lane_val)
    );

    pk_pack_acc pack_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (start_ok || flush_acc),
        .add_i  (take_acc),
        .fmt_i  (fmt_q),
        .lane_i (lane_q),
        .din_i  (tgt_in_data_i),
        .acc_o  (acc_q)
    );

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (count_i == '0)  state_d = ST_FINISH;
                    else if (dir_i)     state_d = ST_COLLECT;
                    else                state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_rd_valid_i) state_d = ST_EMIT;
            end
            ST_EMIT: begin
                if (tgt_out_ready_i) begin
                    if (last_val)       state_d = ST_FINISH;
                    else if (last_lane) state_d = ST_FETCH;
                end
            end
            ST_COLLECT: begin
                if (tgt_in_valid_i && (last_val || last_lane)) state_d = ST_FLUSH;
            end
            ST_FLUSH: begin
                if (mem_wr_ready_i) state_d = rem_zero ? ST_FINISH : ST_COLLECT;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transfer-scoped datapath registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q  <= FMT_NONE;
            hold_q <= '0;
        end else begin
            if (start_ok)  fmt_q  <= pk_fmt_e'(fmt_i);
            if (fetch_acc) hold_q <= mem_rd_data_i;
        end
    end

    // Outputs decoded from state.
    always_comb begin
        busy_o          = (state_q != ST_IDLE);
        done_o          = (state_q == ST_FINISH);
        mem_rd_ready_o  = (state_q == ST_FETCH);
        tgt_out_valid_o = (state_q == ST_EMIT);
        tgt_in_ready_o  = (state_q == ST_COLLECT);
        mem_wr_valid_o  = (state_q == ST_FLUSH);
        tgt_out_data_o  = lane_val;
        mem_wr_data_o   = acc_q;
    end

endmodule

// File: rtl/pk_word_packer_chk.sv
module pk_word_packer_chk
    import pk_types_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  busy_o,
    input logic                  done_o,
    input pk_fmt_e               fmt_q,
    input logic [LANE_IDX_W-1:0] lane_q,
    input logic                  mem_rd_ready_o,
    input logic                  tgt_out_valid_o,
    input logic [WORD_W-1:0]     tgt_out_data_o,
    input logic                  tgt_out_ready_i,
    input logic                  tgt_in_ready_o,
    input logic                  mem_wr_valid_o,
    input logic [WORD_W-1:0]     mem_wr_data_o,
    input logic                  mem_wr_ready_i
);

    // R1: the sampled format holds for the whole transfer
    assert_fmt_held_R1: assert property (@(posedge clk) disable iff (rst)
        busy_o && !done_o |=> $stable(fmt_q));

    // R2: the lane index stays inside the format's lane count
    assert_lane_range_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> ({1'b0, lane_q} < lanes_of(fmt_q)));

    // R5: emitted target words carry nothing above the lane width
    assert_narrow_out_R5: assert property (@(posedge clk) disable iff (rst)
        tgt_out_valid_o |-> ((tgt_out_data_o & ~lane_mask(fmt_q)) == '0));

    // R6: the two spare bits of the ten-bit format stay clear
    assert_spare_bits_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid_o && (fmt_q == FMT_3X10) |-> (mem_wr_data_o[31:30] == 2'b00));

    // R7: an unaccepted target word is held
    assert_tgt_hold_R7: assert property (@(posedge clk) disable iff (rst)
        tgt_out_valid_o && !tgt_out_ready_i |=> tgt_out_valid_o && $stable(tgt_out_data_o));

    // R7: an unaccepted memory word is held
    assert_mem_hold_R7: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid_o && !mem_wr_ready_i |=> mem_wr_valid_o && $stable(mem_wr_data_o));

    // R8: done lasts one cycle and ends the transfer
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o && !busy_o);

    // R9: the two directions never handshake together
    assert_dir_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_ready_o || tgt_out_valid_o) |-> !(tgt_in_ready_o || mem_wr_valid_o));

    // R10: reset leaves every handshake output idle
    assert_reset_idle_R10: assert property (@(posedge clk)
        rst |=> !busy_o && !done_o && !tgt_out_valid_o && !mem_wr_valid_o
                && !mem_rd_ready_o && !tgt_in_ready_o);

endmodule

bind pk_word_packer pk_word_packer_chk chk_i (
    .clk             (clk),
    .rst             (rst),
    .busy_o          (busy_o),
    .done_o          (done_o),
    .fmt_q           (fmt_q),
    .lane_q          (lane_q),
    .mem_rd_ready_o  (mem_rd_ready_o),
    .tgt_out_valid_o (tgt_out_valid_o),
    .tgt_out_data_o  (tgt_out_data_o),
    .tgt_out_ready_i (tgt_out_ready_i),
    .tgt_in_ready_o  (tgt_in_ready_o),
    .mem_wr_valid_o  (mem_wr_valid_o),
    .mem_wr_data_o   (mem_wr_data_o),
    .mem_wr_ready_i  (mem_wr_ready_i)
);

// File: tb/pk_word_packer_tb_top.sv
`timescale 1ns/1ps
module pk_word_packer_tb_top;

    localparam int CNT_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_in = 1'b0;
    logic              dir_in = 1'b0;
    logic [1:0]        fmt_in = 2'b00;
    logic [CNT_W-1:0]  count_in = '0;
    logic              busy_o, done_o;
    logic              mem_rd_valid_in = 1'b0;
    logic [31:0]       mem_rd_data_in = '0;
    logic              mem_rd_ready_o;
    logic              tgt_out_valid_o;
    logic [31:0]       tgt_out_data_o;
    logic              tgt_out_ready_in = 1'b0;
    logic              tgt_in_valid_in = 1'b0;
    logic [31:0]       tgt_in_data_in = '0;
    logic              tgt_in_ready_o;
    logic              mem_wr_valid_o;
    logic [31:0]       mem_wr_data_o;
    logic              mem_wr_ready_in = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pk_word_packer #(.CNT_W(CNT_W)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start_in),
        .dir_i           (dir_in),
        .fmt_i           (fmt_in),
        .count_i         (count_in),
        .busy_o          (busy_o),
        .done_o          (done_o),
        .mem_rd_valid_i  (mem_rd_valid_in),
        .mem_rd_data_i   (mem_rd_data_in),
        .mem_rd_ready_o  (mem_rd_ready_o),
        .tgt_out_valid_o (tgt_out_valid_o),
        .tgt_out_data_o  (tgt_out_data_o),
        .tgt_out_ready_i (tgt_out_ready_in),
        .tgt_in_valid_i  (tgt_in_valid_in),
        .tgt_in_data_i   (tgt_in_data_in),
        .tgt_in_ready_o  (tgt_in_ready_o),
        .mem_wr_valid_o  (mem_wr_valid_o),
        .mem_wr_data_o   (mem_wr_data_o),
        .mem_wr_ready_i  (mem_wr_ready_in)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got=%h exp=%h", req, what, got, exp);
        end
    endtask

    // Reference model built from the requirement text.
    function automatic int ref_lanes(input int f);
        return f + 1;
    endfunction

    function automatic int ref_width(input int f);
        case (f)
            0:       return 32;
            1:       return 16;
            2:       return 10;
            default: return 8;
        endcase
    endfunction

    function automatic logic [31:0] mem_word(input int i);
        return 32'h1F2E_3D4C + 32'(i) * 32'h6B8B_4567;
    endfunction

    function automatic logic [31:0] tgt_word(input int n);
        return (32'(n + 1) * 32'h9E37_79B9) ^ 32'hF0F0_0000;
    endfunction

    function automatic logic [31:0] ref_extract(input logic [31:0] w, input int f, input int k);
        logic [63:0] m;
        logic [63:0] v;
        m = (64'd1 << ref_width(f)) - 64'd1;
        v = ({32'd0, w} >> (k * ref_width(f))) & m;
        return v[31:0];
    endfunction

    function automatic logic [31:0] ref_pack(input int f, input int cnt, input int j);
        logic [63:0] m;
        logic [63:0] a;
        int lanes;
        lanes = ref_lanes(f);
        m = (64'd1 << ref_width(f)) - 64'd1;
        a = '0;
        for (int k = 0; k < lanes; k++) begin
            if (j * lanes + k < cnt)
                a = a | ((({32'd0, tgt_word(j * lanes + k)}) & m) << (k * ref_width(f)));
        end
        return a[31:0];
    endfunction

    task automatic test_reset();
        @(negedge clk);
        #1;
        // R10: idle outputs while reset is held
        chk(!busy_o && !done_o, "R10", "busy/done in reset", {30'd0, busy_o, done_o}, 32'd0);
        chk(!tgt_out_valid_o && !mem_wr_valid_o && !mem_rd_ready_o && !tgt_in_ready_o,
            "R10", "handshakes in reset",
            {28'd0, tgt_out_valid_o, mem_wr_valid_o, mem_rd_ready_o, tgt_in_ready_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(!busy_o, "R10", "idle after reset", {31'd0, busy_o}, 32'd0);
    endtask

    // Unpack: memory words to target words.
    task automatic run_write(input int f, input int cnt, input bit stall, input bit poke);
        int lanes, mi, nout, last_acc, it;
        bit seen, pend;
        logic [31:0] pdata;
        lanes = ref_lanes(f); mi = 0; nout = 0; last_acc = -10; it = 0;
        seen = 1'b0; pend = 1'b0; pdata = '0;
        @(negedge clk);
        dir_in = 1'b0; fmt_in = 2'(f); count_in = CNT_W'(cnt); start_in = 1'b1;
        while (!seen && it < 400) begin
            @(negedge clk);
            // R1, R9: later inputs and a stray start must not disturb the transfer
            start_in = poke && (it == 2);
            dir_in   = poke && (it == 2);
            fmt_in   = ~2'(f);
            count_in = CNT_W'(cnt + 5);
            mem_rd_valid_in  = !(stall && (it % 4 == 3));
            mem_rd_data_in   = mem_word(mi);
            tgt_out_ready_in = !(stall && (it % 3 == 1));
            #1;
            if (it == 0) chk(busy_o, "R9", "busy after start", {31'd0, busy_o}, 32'd1);
            if (pend) begin
                chk(tgt_out_valid_o && (tgt_out_data_o == pdata), "R7", "target word held",
                    tgt_out_data_o, pdata);
                pend = 1'b0;
            end
            if (done_o) begin
                chk(last_acc == it - 1, "R8", "unpack done delay", 32'(it - last_acc), 32'd1);
                seen = 1'b1;
            end
            chk(!(tgt_in_ready_o || mem_wr_valid_o), "R9", "pack side idle during unpack",
                {30'd0, tgt_in_ready_o, mem_wr_valid_o}, 32'd0);
            if (tgt_out_valid_o) begin
                if (tgt_out_ready_in) begin
                    // R2/R3/R5: lane order, pass-through, zero above lane width
                    chk(tgt_out_data_o == ref_extract(mem_word(nout / lanes), f, nout % lanes),
                        (f == 0) ? "R3" : "R2", "unpacked value",
                        tgt_out_data_o, ref_extract(mem_word(nout / lanes), f, nout % lanes));
                    nout++;
                    last_acc = it;
                end else begin
                    pend  = 1'b1;
                    pdata = tgt_out_data_o;
                end
            end
            if (mem_rd_valid_in && mem_rd_ready_o) mi++;
            it++;
        end
        start_in = 1'b0; dir_in = 1'b0; mem_rd_valid_in = 1'b0; tgt_out_ready_in = 1'b0;
        chk(seen, "R8", "unpack done seen", {31'd0, seen}, 32'd1);
        chk(nout == cnt, "R4", "target words emitted", 32'(nout), 32'(cnt));
        chk(mi == (cnt + lanes - 1) / lanes, "R5", "memory words fetched",
            32'(mi), 32'((cnt + lanes - 1) / lanes));
        @(negedge clk);
        #1;
        chk(!done_o && !busy_o, "R8", "done is one cycle", {30'd0, done_o, busy_o}, 32'd0);
    endtask

    // Pack: target words to memory words.
    task automatic run_read(input int f, input int cnt, input bit stall, input bit poke);
        int lanes, ti, wi, last_acc, it;
        bit seen, pend;
        logic [31:0] pdata;
        lanes = ref_lanes(f); ti = 0; wi = 0; last_acc = -10; it = 0;
        seen = 1'b0; pend = 1'b0; pdata = '0;
        @(negedge clk);
        dir_in = 1'b1; fmt_in = 2'(f); count_in = CNT_W'(cnt); start_in = 1'b1;
        while (!seen && it < 400) begin
            @(negedge clk);
            start_in = poke && (it == 2);
            dir_in   = !(poke && (it == 2));
            fmt_in   = ~2'(f);
            count_in = CNT_W'(cnt + 3);
            tgt_in_valid_in = (ti < cnt) && !(stall && (it % 3 == 2));
            tgt_in_data_in  = tgt_word(ti);
            mem_wr_ready_in = !(stall && (it % 4 == 1));
            #1;
            if (pend) begin
                chk(mem_wr_valid_o && (mem_wr_data_o == pdata), "R7", "memory word held",
                    mem_wr_data_o, pdata);
                pend = 1'b0;
            end
            if (done_o) begin
                chk(last_acc == it - 1, "R8", "pack done delay", 32'(it - last_acc), 32'd1);
                seen = 1'b1;
            end
            if (tgt_in_valid_in && tgt_in_ready_o) ti++;
            if (mem_wr_valid_o) begin
                if (mem_wr_ready_in) begin
                    // R6: lane placement, zero unused lanes, ignored high input bits
                    chk(mem_wr_data_o == ref_pack(f, cnt, wi), (f == 0) ? "R3" : "R6",
                        "packed word", mem_wr_data_o, ref_pack(f, cnt, wi));
                    wi++;
                    last_acc = it;
                end else begin
                    pend  = 1'b1;
                    pdata = mem_wr_data_o;
                end
            end
            it++;
        end
        start_in = 1'b0; dir_in = 1'b0; tgt_in_valid_in = 1'b0; mem_wr_ready_in = 1'b0;
        chk(seen, "R8", "pack done seen", {31'd0, seen}, 32'd1);
        chk(ti == cnt, "R4", "target words taken", 32'(ti), 32'(cnt));
        chk(wi == (cnt + lanes - 1) / lanes, "R6", "memory words written",
            32'(wi), 32'((cnt + lanes - 1) / lanes));
        @(negedge clk);
        #1;
        chk(!done_o && !busy_o, "R8", "done is one cycle", {30'd0, done_o, busy_o}, 32'd0);
    endtask

    task automatic test_count_zero(input bit dir);
        @(negedge clk);
        dir_in = dir; fmt_in = 2'b11; count_in = '0; start_in = 1'b1;
        @(negedge clk);
        start_in = 1'b0;
        #1;
        chk(done_o, "R8", "zero-length done", {31'd0, done_o}, 32'd1);
        chk(!tgt_out_valid_o && !mem_wr_valid_o && !mem_rd_ready_o && !tgt_in_ready_o,
            "R4", "zero-length moves nothing",
            {28'd0, tgt_out_valid_o, mem_wr_valid_o, mem_rd_ready_o, tgt_in_ready_o}, 32'd0);
        @(negedge clk);
        #1;
        chk(!done_o && !busy_o, "R8", "zero-length idle", {30'd0, done_o, busy_o}, 32'd0);
    endtask

    // R10: abort a pack mid-word, then a fresh one-value pack must show only lane 0
    task automatic test_abort();
        @(negedge clk);
        dir_in = 1'b1; fmt_in = 2'b11; count_in = CNT_W'(4); start_in = 1'b1;
        @(negedge clk);
        start_in = 1'b0; tgt_in_valid_in = 1'b1; tgt_in_data_in = 32'hFFFF_FFAB;
        @(negedge clk);
        tgt_in_data_in = 32'hFFFF_FFCD;
        @(negedge clk);
        tgt_in_valid_in = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(!busy_o && !tgt_in_ready_o, "R10", "reset aborts transfer",
            {30'd0, busy_o, tgt_in_ready_o}, 32'd0);
        dir_in = 1'b0;
        run_read(3, 1, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R8 watchdog expired got=%h exp=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        run_write(0, 3, 1'b0, 1'b0);
        run_write(1, 5, 1'b1, 1'b0);
        run_write(2, 7, 1'b1, 1'b1);
        run_write(3, 6, 1'b0, 1'b0);
        run_write(3, 9, 1'b1, 1'b1);
        run_read(0, 2, 1'b0, 1'b0);
        run_read(1, 3, 1'b1, 1'b0);
        run_read(2, 5, 1'b1, 1'b1);
        run_read(3, 7, 1'b0, 1'b0);
        run_read(2, 6, 1'b1, 1'b0);
        test_count_zero(1'b0);
        test_count_zero(1'b1);
        test_abort();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule